// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is a small register-transfer core run by a hardwired state machine. Each instruction moves through a fixed series of clock slots. It fetches the word, resolves one level of indirection when the word asks for it, and executes. At the instruction boundary it can also divert into a short interrupt entry. The core holds a program counter, a memory address register, a memory buffer register, an instruction register and one accumulator. It talks to a single-port synchronous memory that returns read data one cycle after the read strobe.

Three memory-reference operations are decoded. The first adds a memory word into the accumulator. The second increments a memory word in place and skips the next instruction when the result wraps to zero. The third stores the return address at the target and continues one word past it. The slot grouping keeps every register transfer causal: within one slot, no register is loaded and also used as a source. A memory read always spends one slot issuing the strobe and a second slot capturing the data.

The interrupt request is looked at only in the final slot of an instruction, and only while the interrupt-enable flag is set. Taking an interrupt saves the program counter at a fixed address, jumps to a fixed routine address and clears the flag. A separate pulse input sets the flag again.

Top module: `rt_ctrl_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_out` equals RESET_PC (default 0), `acc_out` and `int_en` are 0, and neither memory strobe is high. The first access after release is a read of RESET_PC in the second cycle.
- R2: Every instruction starts with a 4-cycle fetch. In its second cycle the fetch reads address PC and advances PC by one, modulo 2^ADDR_W. The returned word becomes the instruction.
- R3: A read is a single-cycle `mem_rd` pulse with `mem_addr` valid, and the data is taken from `mem_rdata` in the following cycle. A write is a single-cycle `mem_wr` pulse with `mem_addr` and `mem_wdata` valid. The two strobes are never high together.
- R4: Instruction layout, with the 16-bit default: bits [15:13] are the opcode (0 add, 1 increment-and-skip, 2 branch-and-save), bit 12 is the indirect flag and bits [11:0] are the address. Opcodes 3 to 7 end the instruction right after fetch (and indirection), with no further access and no register change.
- R5: With the indirect flag set, 4 more cycles follow the fetch. The second of them reads the address field, and the low ADDR_W bits of the returned word become the effective address. The opcode is kept.
- R6: Add takes 4 cycles. It reads the effective address in its second cycle, then sets the accumulator to accumulator plus word, modulo 2^16. No other path changes the accumulator.
- R7: Increment-and-skip takes 5 cycles. It reads the effective address in its second cycle and writes word+1 (mod 2^16) back to that address in its fifth cycle. When the written value is 0, PC advances once more, which skips the next word.
- R8: Branch-and-save takes 3 cycles. In its second cycle it writes the current PC (the address of the following word, zero-extended) to the effective address. Execution then continues at effective address + 1.
- R9: If `int_req` and `int_en` are both 1 in the last cycle of an instruction, a 3-cycle interrupt entry follows. It writes PC (zero-extended) to SAVE_ADDR in its third cycle, the next fetch reads ISR_ADDR, and `int_en` drops after the entry's first cycle.
- R10: A one-cycle `int_en_set` pulse makes `int_en` 1 from the next cycle on. Only interrupt entry clears it, and the clear wins if both happen in the same cycle. `int_req` has no effect while `int_en` is 0 or outside an instruction's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | Interrupt request level |
| int_en_set | input | 1 | Pulse that sets the interrupt-enable flag |
| mem_addr | output | ADDR_W | Memory address (the address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | ADDR_W+4 | Write data (the buffer register) |
| mem_rdata | input | ADDR_W+4 | Read data, valid one cycle after `mem_rd` |
| pc_out | output | ADDR_W | Program counter |
| acc_out | output | ADDR_W+4 | Accumulator |
| int_en | output | 1 | Interrupt-enable flag |

## Verification
The core is driven with programs whose memory is filled at random. Every word is therefore a legal instruction, with random opcodes, indirect flags and targets, including self-modifying stores. For each program the bench predicts the full cycle-stamped trace of reads and writes, along with the final PC, accumulator and enable flag. The random mix shows whether the slot counts and the transfer order are right under every opcode sequence.

Directed programs cover the cases random data rarely reaches. One increments 0xFFFF, so the skip must happen. One branch-and-save goes through a pointer, which tests indirection feeding a store of the return address. A run of undefined opcodes must cost only the fetch. Interrupt windows and enable pulses are placed so that requests are taken at boundaries, ignored while the flag is clear, and re-armed by a later pulse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OP_ADD = 3'd0;
    localparam logic [OPC_W-1:0] OP_ISZ = 3'd1;
    localparam logic [OPC_W-1:0] OP_BSA = 3'd2;

    // One state per clock slot; the operand slots are kept apart per
    // instruction so the sequencer needs no remembered opcode.
    typedef enum logic [4:0] {
        S_F_MAR, S_F_RD, S_F_MBR, S_F_IR,
        S_N_MAR, S_N_RD, S_N_MBR, S_N_IRA,
        S_A_MAR, S_A_RD, S_A_MBR, S_A_ACC,
        S_Z_MAR, S_Z_RD, S_Z_MBR, S_Z_INC, S_Z_WR,
        S_B_LINK, S_B_JUMP, S_B_STEP,
        S_T_SAVE, S_T_VECT, S_T_WR
    } slot_e;

    typedef struct packed {
        slot_e slot;
        logic  ien;
    } seq_t;

endpackage

// File: rtl/rtc_adder.sv
module rtc_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    assign sum = a + b;
endmodule

// File: rtl/rtc_sequencer.sv
module rtc_sequencer
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] mbr_opc,
    input  logic             mbr_ind,
    input  logic [OPC_W-1:0] ir_opc,
    input  logic             int_req,
    input  logic             int_en_set,
    output slot_e            slot_q,
    output logic             ien_q
);
    seq_t seq_d, seq_q;
    slot_e boundary;

    function automatic slot_e dispatch(input logic [OPC_W-1:0] opc, input slot_e fin);
        unique case (opc)
            OP_ADD:  return S_A_MAR;
            OP_ISZ:  return S_Z_MAR;
            OP_BSA:  return S_B_LINK;
            default: return fin;
        endcase
    endfunction

    always_comb begin
        seq_d    = seq_q;
        boundary = (int_req && seq_q.ien) ? S_T_SAVE : S_F_MAR;
        unique case (seq_q.slot)
            S_F_MAR:  seq_d.slot = S_F_RD;
            S_F_RD:   seq_d.slot = S_F_MBR;
            S_F_MBR:  seq_d.slot = S_F_IR;
            S_F_IR:   seq_d.slot = mbr_ind ? S_N_MAR : dispatch(mbr_opc, boundary);
            S_N_MAR:  seq_d.slot = S_N_RD;
            S_N_RD:   seq_d.slot = S_N_MBR;
            S_N_MBR:  seq_d.slot = S_N_IRA;
            S_N_IRA:  seq_d.slot = dispatch(ir_opc, boundary);
            S_A_MAR:  seq_d.slot = S_A_RD;
            S_A_RD:   seq_d.slot = S_A_MBR;
            S_A_MBR:  seq_d.slot = S_A_ACC;
            S_A_ACC:  seq_d.slot = boundary;
            S_Z_MAR:  seq_d.slot = S_Z_RD;
            S_Z_RD:   seq_d.slot = S_Z_MBR;
            S_Z_MBR:  seq_d.slot = S_Z_INC;
            S_Z_INC:  seq_d.slot = S_Z_WR;
            S_Z_WR:   seq_d.slot = boundary;
            S_B_LINK: seq_d.slot = S_B_JUMP;
            S_B_JUMP: seq_d.slot = S_B_STEP;
            S_B_STEP: seq_d.slot = boundary;
            S_T_SAVE: seq_d.slot = S_T_VECT;
            S_T_VECT: seq_d.slot = S_T_WR;
            S_T_WR:   seq_d.slot = S_F_MAR;
            default:  seq_d.slot = S_F_MAR;
        endcase
        if (seq_q.slot == S_T_SAVE) begin
            seq_d.ien = 1'b0;
        end else if (int_en_set) begin
            seq_d.ien = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{slot: S_F_MAR, ien: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_q = seq_q.slot;
    assign ien_q  = seq_q.ien;
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
    import rtc_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '1,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = '0,
    parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_e               slot_q,
    input  logic [ADDR_W+3:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [ADDR_W+3:0]   mem_wdata,
    output logic [OPC_W-1:0]    mbr_opc,
    output logic                mbr_ind,
    output logic [OPC_W-1:0]    ir_opc,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [ADDR_W+3:0]   acc_out
);
    localparam int DATA_W  = ADDR_W + 4;
    localparam int EXT_W   = DATA_W - ADDR_W;
    localparam int OPC_LSB = DATA_W - OPC_W;
    localparam int IND_POS = OPC_LSB - 1;
    localparam logic [ADDR_W-1:0] PC_ONE  = 1;
    localparam logic [DATA_W-1:0] MBR_ONE = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [OPC_W-1:0]  ir_opc;
        logic [ADDR_W-1:0] ir_addr;
        logic [DATA_W-1:0] acc;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  rd_c, wr_c;
    logic [ADDR_W-1:0] pc_inc;
    logic [DATA_W-1:0] mbr_inc, acc_sum;

    rtc_adder #(.W(ADDR_W)) u_pc_inc  (.a(regs_q.pc),  .b(PC_ONE),     .sum(pc_inc));
    rtc_adder #(.W(DATA_W)) u_mbr_inc (.a(regs_q.mbr), .b(MBR_ONE),    .sum(mbr_inc));
    rtc_adder #(.W(DATA_W)) u_acc_add (.a(regs_q.acc), .b(regs_q.mbr), .sum(acc_sum));

    always_comb begin
        regs_d = regs_q;
        rd_c   = 1'b0;
        wr_c   = 1'b0;
        unique case (slot_q)
            S_F_MAR: regs_d.mar = regs_q.pc;
            S_F_RD: begin
                rd_c      = 1'b1;
                regs_d.pc = pc_inc;
            end
            S_F_IR: begin
                regs_d.ir_opc  = regs_q.mbr[DATA_W-1:OPC_LSB];
                regs_d.ir_addr = regs_q.mbr[ADDR_W-1:0];
            end
            S_N_MAR, S_A_MAR, S_Z_MAR: regs_d.mar = regs_q.ir_addr;
            S_N_RD, S_A_RD, S_Z_RD:    rd_c = 1'b1;
            S_F_MBR, S_N_MBR, S_A_MBR, S_Z_MBR: regs_d.mbr = mem_rdata;
            S_N_IRA: regs_d.ir_addr = regs_q.mbr[ADDR_W-1:0];
            S_A_ACC: regs_d.acc = acc_sum;
            S_Z_INC: regs_d.mbr = mbr_inc;
            S_Z_WR: begin
                wr_c = 1'b1;
                if (regs_q.mbr == '0) begin
                    regs_d.pc = pc_inc;
                end
            end
            S_B_LINK: begin
                regs_d.mar = regs_q.ir_addr;
                regs_d.mbr = {{EXT_W{1'b0}}, regs_q.pc};
            end
            S_B_JUMP: begin
                regs_d.pc = regs_q.ir_addr;
                wr_c      = 1'b1;
            end
            S_B_STEP: regs_d.pc = pc_inc;
            S_T_SAVE: regs_d.mbr = {{EXT_W{1'b0}}, regs_q.pc};
            S_T_VECT: begin
                regs_d.mar = SAVE_ADDR;
                regs_d.pc  = ISR_ADDR;
            end
            S_T_WR:  wr_c = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.pc <= RESET_PC;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_addr  = regs_q.mar;
    assign mem_rd    = rd_c;
    assign mem_wr    = wr_c;
    assign mem_wdata = regs_q.mbr;
    assign mbr_opc   = regs_q.mbr[DATA_W-1:OPC_LSB];
    assign mbr_ind   = regs_q.mbr[IND_POS];
    assign ir_opc    = regs_q.ir_opc;
    assign pc_out    = regs_q.pc;
    assign acc_out   = regs_q.acc;
endmodule

// File: rtl/rt_ctrl_core.sv
module rt_ctrl_core
    import rtc_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'hFF0,
    parameter logic [ADDR_W-1:0] ISR_ADDR  = 12'hF00,
    parameter logic [ADDR_W-1:0] RESET_PC  = 12'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_req,
    input  logic              int_en_set,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W+3:0] mem_wdata,
    input  logic [ADDR_W+3:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W+3:0] acc_out,
    output logic              int_en
);
    slot_e            slot_q;
    logic [OPC_W-1:0] mbr_opc, ir_opc;
    logic             mbr_ind;

    rtc_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mbr_opc    (mbr_opc),
        .mbr_ind    (mbr_ind),
        .ir_opc     (ir_opc),
        .int_req    (int_req),
        .int_en_set (int_en_set),
        .slot_q     (slot_q),
        .ien_q      (int_en)
    );

    rtc_datapath #(
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .ISR_ADDR  (ISR_ADDR),
        .RESET_PC  (RESET_PC)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_q    (slot_q),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mbr_opc   (mbr_opc),
        .mbr_ind   (mbr_ind),
        .ir_opc    (ir_opc),
        .pc_out    (pc_out),
        .acc_out   (acc_out)
    );
endmodule

// File: rtl/rt_ctrl_core_chk.sv
module rt_ctrl_core_chk
    import rtc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              int_en,
    input logic              int_en_set,
    input logic [DATA_W-1:0] acc_out,
    input slot_e             slot
);
    // R3: a slot never both reads and writes memory
    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3: a read strobe is one cycle; the next slot captures the data
    assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3: a write strobe is one cycle
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R6: the accumulator moves only after the add slot
    assert_acc_only_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> ($past(slot) == S_A_ACC));

    // R10: the enable flag rises only after a set pulse
    assert_ien_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_en) |-> $past(int_en_set));

    // R9: the enable flag falls only on interrupt entry
    assert_ien_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_en) |-> ($past(slot) == S_T_SAVE));
endmodule

bind rt_ctrl_core rt_ctrl_core_chk #(.DATA_W(ADDR_W + 4)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .int_en     (int_en),
    .int_en_set (int_en_set),
    .acc_out    (acc_out),
    .slot       (slot_q)
);

// File: tb/rt_ctrl_core_tb.sv
module rt_ctrl_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE = 4096;
    localparam logic [11:0] SAVE = 12'hFF0;
    localparam logic [11:0] ISR  = 12'hF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_req = 1'b0;
    logic        int_en_set = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [11:0] pc_out;
    logic [15:0] acc_out;
    logic        int_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mem [0:4095];
    logic [15:0] mm  [0:4095];

    int          exp_cyc  [0:MAXE-1];
    bit          exp_wr   [0:MAXE-1];
    logic [11:0] exp_addr [0:MAXE-1];
    logic [15:0] exp_data [0:MAXE-1];
    string       exp_tag  [0:MAXE-1];
    int          n_exp;

    int irq_lo, irq_hi, p0, p1;
    logic [11:0] m_pc;
    logic [15:0] m_acc;
    bit          m_ien;
    int          m_end;

    rt_ctrl_core #(.ADDR_W(12), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR), .RESET_PC(12'h000)) u_dut (
        .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_en_set(int_en_set),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .acc_out(acc_out), .int_en(int_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // synchronous memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] instr(input logic [2:0] op, input bit ind, input logic [11:0] a);
        return {op, ind, a};
    endfunction

    function automatic bit irq_at(input int d);
        return (d >= irq_lo) && (d < irq_hi);
    endfunction

    function automatic bit ien_at(input int d, input int last_clr);
        return ((p0 > last_clr) && (p0 <= d - 1)) || ((p1 > last_clr) && (p1 <= d - 1));
    endfunction

    task automatic push(input int c, input bit wr, input logic [11:0] a, input logic [15:0] d, input string tag);
        if (n_exp < MAXE) begin
            exp_cyc[n_exp]  = c;
            exp_wr[n_exp]   = wr;
            exp_addr[n_exp] = a;
            exp_data[n_exp] = d;
            exp_tag[n_exp]  = tag;
            n_exp++;
        end
    endtask

    // instruction-level reference with slot counts from the requirements
    task automatic model(input int limit);
        logic [11:0] pc, ea;
        logic [15:0] ir, acc, v;
        int c, last_clr;
        pc = 12'h000; acc = '0; c = 0; last_clr = -1; n_exp = 0;
        while (c < limit) begin
            push(c + 1, 1'b0, pc, '0, "R2");
            ir = mm[pc]; pc = pc + 12'd1; c += 4;
            ea = ir[11:0];
            if (ir[12]) begin
                push(c + 1, 1'b0, ea, '0, "R5");
                ea = mm[ea][11:0]; c += 4;
            end
            case (ir[15:13])
                3'd0: begin
                    push(c + 1, 1'b0, ea, '0, "R6");
                    acc = acc + mm[ea]; c += 4;
                end
                3'd1: begin
                    push(c + 1, 1'b0, ea, '0, "R7");
                    v = mm[ea] + 16'd1;
                    push(c + 4, 1'b1, ea, v, "R7");
                    mm[ea] = v;
                    if (v == 16'd0) pc = pc + 12'd1;
                    c += 5;
                end
                3'd2: begin
                    push(c + 1, 1'b1, ea, {4'h0, pc}, "R8");
                    mm[ea] = {4'h0, pc}; pc = ea + 12'd1; c += 3;
                end
                default: ;
            endcase
            if (irq_at(c - 1) && ien_at(c - 1, last_clr)) begin
                push(c + 2, 1'b1, SAVE, {4'h0, pc}, "R9");
                mm[SAVE] = {4'h0, pc}; pc = ISR; last_clr = c; c += 3;
            end
        end
        m_pc = pc; m_acc = acc; m_end = c; m_ien = ien_at(c, last_clr);
    endtask

    task automatic begin_test();
        rst_n = 1'b0; int_req = 1'b0; int_en_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input bit rnd);
        for (int i = 0; i < 4096; i++) mem[i] = rnd ? 16'($urandom) : 16'h0000;
    endtask

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic run_test(input string name, input int limit);
        int idx;
        bit exp_here, obs, ok;
        for (int i = 0; i < 4096; i++) mm[i] = mem[i];
        model(limit);
        @(negedge clk);
        // R1: reset state
        check(pc_out == 12'h000, {"R1 pc in reset, ", name}, 32'(pc_out), 32'h0);
        check(acc_out == 16'h0 && int_en == 1'b0, {"R1 acc/int_en in reset, ", name},
              {15'h0, int_en, acc_out}, 32'h0);
        check(!mem_rd && !mem_wr, {"R1 strobes in reset, ", name}, {30'h0, mem_rd, mem_wr}, 32'h0);
        rst_n = 1'b1;
        idx = 0;
        for (int c = 0; c <= m_end; c++) begin
            if (c > 0) @(negedge clk);
            if (c < m_end) begin
                exp_here = (idx < n_exp) && (exp_cyc[idx] == c);
                obs = mem_rd || mem_wr;
                if (exp_here || obs) begin
                    ok = exp_here && obs && (mem_wr == exp_wr[idx]) && (mem_rd == !exp_wr[idx])
                         && (mem_addr == exp_addr[idx]) && (!exp_wr[idx] || mem_wdata == exp_data[idx]);
                    checks++;
                    if (!ok) begin
                        errors++;
                        if (exp_here)
                            $display("FAIL %s R3 %s cycle %0d: actual rd=%0b wr=%0b addr=%0h data=%0h expected wr=%0b addr=%0h data=%0h",
                                     exp_tag[idx], name, c, mem_rd, mem_wr, mem_addr, mem_wdata,
                                     exp_wr[idx], exp_addr[idx], exp_data[idx]);
                        else
                            $display("FAIL R3 %s cycle %0d: actual rd=%0b wr=%0b addr=%0h expected no access",
                                     name, c, mem_rd, mem_wr, mem_addr);
                    end
                    if (exp_here) idx++;
                end
            end
            int_req    = irq_at(c);
            int_en_set = (c == p0) || (c == p1);
            if (c == m_end) begin
                check(pc_out == m_pc, {"R2 final pc, ", name}, 32'(pc_out), 32'(m_pc));
                check(acc_out == m_acc, {"R6 final acc, ", name}, 32'(acc_out), 32'(m_acc));
                check(int_en == m_ien, {"R10 final int_en, ", name}, 32'(int_en), 32'(m_ien));
                check(idx == n_exp, {"R3 access count, ", name}, 32'(idx), 32'(n_exp));
            end
        end
        int_req = 1'b0; int_en_set = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));

        // R7: increment wraps to zero and skips the next word
        begin_test(); fill(1'b0);
        mem[0] = instr(3'd1, 1'b0, 12'h100); mem[12'h100] = 16'hFFFF;
        mem[1] = instr(3'd0, 1'b0, 12'h101); mem[12'h101] = 16'h0005;
        mem[2] = instr(3'd0, 1'b0, 12'h102); mem[12'h102] = 16'h0007;
        mem[3] = instr(3'd1, 1'b0, 12'h103); mem[12'h103] = 16'h0010;
        irq_lo = 0; irq_hi = 0; p0 = -1; p1 = -1;
        run_test("R7 skip on zero", 40);
        check(mem[12'h100] == 16'h0000 && mem[12'h103] == 16'h0011, "R7 stored increments",
              {mem[12'h100], mem[12'h103]}, 32'h0000_0011);

        // R5 and R8: branch-and-save through a pointer
        begin_test(); fill(1'b0);
        mem[0] = instr(3'd2, 1'b1, 12'h200); mem[12'h200] = 16'hA300;
        mem[12'h301] = instr(3'd0, 1'b1, 12'h210); mem[12'h210] = 16'h0220;
        mem[12'h220] = 16'h1234;
        irq_lo = 0; irq_hi = 0; p0 = -1; p1 = -1;
        run_test("R5 R8 indirect branch-and-save", 40);
        check(mem[12'h300] == 16'h0001, "R8 saved return address", 32'(mem[12'h300]), 32'h1);

        // R4: undefined opcodes cost only the fetch
        begin_test(); fill(1'b0);
        mem[0] = instr(3'd5, 1'b0, 12'h050);
        mem[1] = instr(3'd7, 1'b1, 12'h060); mem[12'h060] = 16'h0070;
        mem[2] = instr(3'd3, 1'b0, 12'h000);
        mem[3] = instr(3'd0, 1'b0, 12'h080); mem[12'h080] = 16'h0042;
        irq_lo = 0; irq_hi = 0; p0 = -1; p1 = -1;
        run_test("R4 undefined opcode", 30);

        // R9 and R10: request held, enable pulses at start and later
        begin_test(); fill(1'b1);
        irq_lo = 0; irq_hi = 100000; p0 = 0; p1 = 60;
        run_test("R9 R10 interrupt entry and re-arm", 150);

        // R10: request present but flag never set
        begin_test(); fill(1'b1);
        irq_lo = 0; irq_hi = 100000; p0 = -1; p1 = -1;
        run_test("R10 request ignored while disabled", 120);

        // R10: set pulse in the cycle of interrupt entry loses to the clear
        begin_test(); fill(1'b0);
        irq_lo = 0; irq_hi = 100000; p0 = 0; p1 = 8;
        run_test("R10 clear wins over set", 60);

        // random programs, random request windows and enable pulses
        for (int t = 0; t < 10; t++) begin
            begin_test(); fill(1'b1);
            irq_lo = $urandom_range(0, 300);
            irq_hi = irq_lo + $urandom_range(0, 200);
            p0 = $urandom_range(0, 400);
            p1 = $urandom_range(0, 400);
            run_test($sformatf("random program %0d", t), 500);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule